// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that gives a host access to a small bank of configuration registers. Each access is one frame of exactly sixteen bits, framed by an active-low select. The first eight bits are a command byte that only the host sends. It holds a direction flag and a register address. The last eight bits are data: on a write the host shifts the data in, and on a read the block shifts the addressed register out. The current contents of every register are presented continuously on a flat parallel bus for the datapath to use.

The serial pins are sampled by the block's own system clock through a synchronizer, so the serial clock must run well below that clock. The output pin is driven only while the data byte of a read is in flight and is released at all other times. This lets a board join the input and output lines into one bidirectional wire (3-wire use) or keep them separate (4-wire use). Once a frame has used its sixteen bits, the select line must go high before another frame is accepted. The port does not depend on any low-power state of the surrounding datapath.

Top module: `serial_cfg_port`

## Requirements
- R1: While `rst` is high and after it falls, register i holds (i*17) mod 256, `sdo_oe` is 0, and `sdo` is released.
- R2: A frame whose command bit 7 is 0 writes its data byte into the register selected by command bits 4:0. Both bytes are sent MSB first and captured on rising `sclk` edges. The new value appears on `cfg_flat[8*i +: 8]` only after the eighth data bit.
- R3: A frame whose command bit 7 is 1 shifts the addressed register out MSB first on `sdo`. Each bit changes after a falling `sclk` edge and is stable at the next rising edge, over data-byte clocks 9 to 16. The register itself is not changed.
- R4: `sdo_oe` is 1 only while the data byte of a read is in progress. It is 0 during every command byte, during the whole of a write, and while `cs_n` is high.
- R5: A write frame cut short by `cs_n` rising before the eighth data bit leaves every register unchanged.
- R6: After the sixteenth bit, further `sclk` edges are ignored until `cs_n` goes high. A later frame after `cs_n` has risen is accepted normally.
- R7: `sclk` and `sdi` activity while `cs_n` is high changes no register and does not enable the output.
- R8: An address at or above `NUM_REGS` makes a write have no effect and makes a read return 0x00.
- R9: The value on `sdi` during the data byte of a read has no effect. This lets `sdi` and `sdo` share one wire.
- R10: Command bits 6:5 are ignored. The frame behaves as if they were 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial bit clock, idle low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial read data, released when not driving |
| sdo_oe | output | 1 | High while `sdo` is driven |
| cfg_flat | output | 8*NUM_REGS | All register contents, register i at bits 8*i+7:8*i |

## Verification
The bench builds the block with `NUM_REGS` = 8 and `SYNC_STAGES` = 2. Because eight registers leave addresses 8 to 31 of the five-bit field unused, both the ignored write and the zero read-back of R8 can be reached. With two synchronizer stages and a serial clock at one sixteenth of the system clock, each serial half period spans eight system cycles. Read data therefore settles well before the host samples it, and frames that are truncated, over-long, or clocked while deselected can be timed exactly.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_CMD,
        FR_WDATA,
        FR_RDATA,
        FR_DONE
    } frame_state_e;

    // bit 7: direction, bits 6:5 unused, bits 4:0 register address
    typedef struct packed {
        logic              is_read;
        logic [1:0]        unused;
        logic [ADDR_W-1:0] addr;
    } cmd_byte_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } reg_write_t;

    function automatic logic [BYTE_W-1:0] reg_reset_value(input int idx);
        return BYTE_W'((idx * 17) % 256);
    endfunction

endpackage

// File: rtl/serial_cfg_sync.sv
module serial_cfg_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/serial_cfg_frame.sv
module serial_cfg_frame
    import serial_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n_s,
    input  logic               sclk_s,
    input  logic               sdi_s,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic [ADDR_W-1:0]  acc_addr,
    output reg_write_t         wr,
    output logic               sdo_bit,
    output logic               sdo_oe
);
    frame_state_e      state;
    logic              sclk_q;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] shift_in;
    logic [BYTE_W-1:0] tx;
    logic              rise, fall;
    logic [BYTE_W-1:0] shifted;
    cmd_byte_t         cmd;

    assign rise    = sclk_s & ~sclk_q;
    assign fall    = ~sclk_s & sclk_q;
    assign shifted = {shift_in[BYTE_W-2:0], sdi_s};
    assign cmd     = cmd_byte_t'(shifted);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= FR_IDLE;
            sclk_q   <= 1'b0;
            bit_cnt  <= '0;
            shift_in <= '0;
            tx       <= '0;
            acc_addr <= '0;
            wr       <= '0;
            sdo_bit  <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            wr.en  <= 1'b0;
            if (cs_n_s) begin
                state   <= FR_IDLE;
                bit_cnt <= '0;
            end else begin
                unique case (state)
                    FR_IDLE: begin
                        state   <= FR_CMD;
                        bit_cnt <= '0;
                    end
                    FR_CMD: if (rise) begin
                        shift_in <= shifted;
                        bit_cnt  <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            acc_addr <= cmd.addr;
                            state    <= cmd.is_read ? FR_RDATA : FR_WDATA;
                        end
                    end
                    FR_WDATA: if (rise) begin
                        shift_in <= shifted;
                        bit_cnt  <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            wr.en   <= 1'b1;
                            wr.addr <= acc_addr;
                            wr.data <= shifted;
                            state   <= FR_DONE;
                        end
                    end
                    FR_RDATA: begin
                        if (fall) begin
                            if (bit_cnt == 3'd0) begin
                                sdo_bit <= rd_data[BYTE_W-1];
                                tx      <= {rd_data[BYTE_W-2:0], 1'b0};
                            end else begin
                                sdo_bit <= tx[BYTE_W-1];
                                tx      <= {tx[BYTE_W-2:0], 1'b0};
                            end
                        end
                        if (rise) begin
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) state <= FR_DONE;
                        end
                    end
                    FR_DONE: ;
                    default: state <= FR_IDLE;
                endcase
            end
        end
    end

    assign sdo_oe = (state == FR_RDATA);

    // R2
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> !wr.en);

    // R5
    wr_from_data_phase_chk: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> $past(state) == FR_WDATA);

    // R4
    oe_released_unselected_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n_s) |-> !sdo_oe);

    // R7
    deselect_idles_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> state == FR_IDLE);

    // R6
    done_is_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (state == FR_DONE && !cs_n_s) |=> state == FR_DONE);
endmodule

// File: rtl/serial_cfg_regbank.sv
module serial_cfg_regbank
    import serial_cfg_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  reg_write_t                   wr,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [BYTE_W-1:0]            rd_data,
    output logic [NUM_REGS*BYTE_W-1:0]   cfg_flat
);
    logic [BYTE_W-1:0] regs_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= reg_reset_value(i);
            end else if (wr.en && wr.addr == ADDR_W'(i)) begin
                regs_q[i] <= wr.data;
            end
        end
        assign cfg_flat[i*BYTE_W +: BYTE_W] = regs_q[i];

        // R2
        reg_takes_write_chk: assert property (@(posedge clk) disable iff (rst)
            (wr.en && wr.addr == ADDR_W'(i)) |=> regs_q[i] == $past(wr.data));

        // R8
        reg_holds_otherwise_chk: assert property (@(posedge clk) disable iff (rst)
            !(wr.en && wr.addr == ADDR_W'(i)) |=> $stable(regs_q[i]));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = regs_q[i];
        end
    end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import serial_cfg_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cs_n,
    input  logic                       sclk,
    input  logic                       sdi,
    output logic                       sdo,
    output logic                       sdo_oe,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_flat
);
    logic [2:0]        pins_s;
    logic [ADDR_W-1:0] acc_addr;
    logic [BYTE_W-1:0] rd_data;
    reg_write_t        wr;
    logic              sdo_bit;

    serial_cfg_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sclk, sdi}),
        .q   (pins_s)
    );

    serial_cfg_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .cs_n_s   (pins_s[2]),
        .sclk_s   (pins_s[1]),
        .sdi_s    (pins_s[0]),
        .rd_data  (rd_data),
        .acc_addr (acc_addr),
        .wr       (wr),
        .sdo_bit  (sdo_bit),
        .sdo_oe   (sdo_oe)
    );

    serial_cfg_regbank #(
        .NUM_REGS (NUM_REGS)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .rd_addr  (acc_addr),
        .rd_data  (rd_data),
        .cfg_flat (cfg_flat)
    );

    assign sdo = sdo_oe ? sdo_bit : 1'bz;
endmodule

// File: tb/serial_cfg_port_tb.sv
module serial_cfg_port_tb_top;
    localparam int NREG = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    wire  sdo;
    logic sdo_oe;
    logic [NREG*8-1:0] cfg_flat;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    serial_cfg_port #(.NUM_REGS(NREG), .SYNC_STAGES(2)) dut_i (
        .clk (clk), .rst (rst), .cs_n (cs_n), .sclk (sclk), .sdi (sdi),
        .sdo (sdo), .sdo_oe (sdo_oe), .cfg_flat (cfg_flat)
    );

    always #2.5 clk = ~clk;

    // {command, data sent, expected register/read value}
    localparam logic [23:0] VEC [12] = '{
        24'h00_A5_A5, 24'h01_3C_3C, 24'h67_FF_FF, 24'h03_00_00,
        24'h80_5A_A5, 24'h81_FF_3C, 24'h87_00_FF, 24'h83_C3_00,
        24'h82_00_22, 24'h14_77_00, 24'h94_00_00, 24'hE5_00_55
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic spi_run(input logic [23:0] bits, input int nbits,
                           output logic [7:0] rd, output int oe_cmd, output int oe_data);
        rd = '0; oe_cmd = 0; oe_data = 0;
        cs_n = 1'b0;
        cyc(8);
        for (int i = 0; i < nbits; i++) begin
            sdi = bits[23-i];
            cyc(8);
            if (i < 8) oe_cmd += int'(sdo_oe);
            else if (i < 16) begin
                oe_data += int'(sdo_oe);
                rd[15-i] = sdo;
            end
            sclk = 1'b1;
            cyc(8);
            sclk = 1'b0;
        end
        cyc(8);
        cs_n = 1'b1;
        sdi  = 1'b0;
        cyc(10);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic [NREG*8-1:0] snap;
        int oc, od;
        cyc(4);
        // R1: reset values during and after reset
        for (int i = 0; i < NREG; i++) check("R1", cfg_flat[i*8 +: 8], (i*17) % 256);
        check("R1 oe", sdo_oe, 0);
        rst = 1'b0;
        cyc(4);
        check("R1 after", cfg_flat, snap_reset());

        for (int v = 0; v < 12; v++) begin
            logic [7:0] cmdb, datb, expb;
            logic [4:0] a;
            {cmdb, datb, expb} = VEC[v];
            a = cmdb[4:0];
            snap = cfg_flat;
            spi_run({cmdb, datb, 8'h00}, 16, rd, oc, od);
            check("R4 cmd oe", oc, 0);
            if (cmdb[7]) begin
                check("R3/R8/R10 read", rd, expb);
                check("R4 read oe", od, 8);
                check("R3/R9 unchanged", cfg_flat, snap);
            end else begin
                check("R4 write oe", od, 0);
                if (a < NREG) check("R2/R10 write", cfg_flat[a*8 +: 8], expb);
                else check("R8 ignored", cfg_flat, snap);
            end
        end

        // R7: activity while deselected
        snap = cfg_flat;
        for (int i = 0; i < 16; i++) begin
            sdi = i[0];
            cyc(8);
            check("R7 oe", sdo_oe, 0);
            sclk = 1'b1; cyc(8); sclk = 1'b0;
        end
        cyc(10);
        check("R7 regs", cfg_flat, snap);

        // R5: truncated write
        spi_run(24'h04_99_00, 13, rd, oc, od);
        check("R5 truncated", cfg_flat[4*8 +: 8], 8'h44);

        // R6: extra bits after a full frame
        spi_run(24'h06_12_FF, 24, rd, oc, od);
        check("R6 extra ignored", cfg_flat[6*8 +: 8], 8'h12);
        spi_run(24'h06_34_00, 16, rd, oc, od);
        check("R6 rearm", cfg_flat[6*8 +: 8], 8'h34);
        spi_run(24'h86_FF_FF, 24, rd, oc, od);
        check("R6 read then extra", rd, 8'h34);
        check("R6 read oe", od, 8);
        check("R4 idle oe", sdo_oe, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    function automatic logic [NREG*8-1:0] snap_reset();
        logic [NREG*8-1:0] r;
        for (int i = 0; i < NREG; i++) r[i*8 +: 8] = 8'((i*17) % 256);
        return r;
    endfunction
endmodule